// File: doc/BRIEF.md
# Four-Channel PWM Run and Interrupt Controller

This block is the global control register file for a bank of four PWM channels. A host reaches it through a simple single-cycle register bus. Through it the host starts and stops channels, chooses which channels may interrupt, and collects end-of-period events. The waveform engines themselves sit outside the block. They take a per-channel run bit from it, and they return a one-cycle pulse each time a period completes.

Run bits and interrupt-mask bits are never written directly. Each has a pair of strobe addresses. A 1 written to a bit of the "set" address turns the channel's bit on, and a 1 written to a bit of the "clear" address turns it off. Zero bits leave the state as it was. End-of-period pulses collect in a sticky pending register. A read of that register returns its contents and empties it, which acknowledges the interrupt. One interrupt line is high while any pending channel is also unmasked. A 32-bit mode word is stored for the clock-divider logic next to the block.

The bus has no back-pressure. Every access with `bus_req` high completes in the cycle it is presented. Read data is combinational from `bus_addr`, and any side effect of an access takes hold at the clock edge that ends it.

Top module: `pwm_run_irq_ctrl`

## Requirements
- R1: After reset, the run bits, the mask, the pending bits, the mode word and `irq` are all zero.
- R2: A write to 0x04 sets every run bit whose data bit is 1, from the next cycle on. Data bits that are 0 change nothing.
- R3: A write to 0x08 clears every run bit whose data bit is 1. Data bits that are 0 change nothing.
- R4: A read of 0x0C returns the run bits in bits [3:0]. A write to 0x0C has no effect.
- R5: A write to 0x10 sets the mask bits named by 1s, and a write to 0x14 clears them. A read of 0x18 returns the mask, and a write to 0x18 has no effect.
- R6: A high `period_done[n]` in any cycle sets pending bit n, and the bit stays set until it is acknowledged.
- R7: A read of 0x1C returns the pending bits in [3:0] and clears them at the end of that access.
- R8: An event that arrives in the same cycle as a read of 0x1C remains pending after the read.
- R9: `irq` is high exactly when some channel is both pending and masked in, from the cycle after the pending bit is set.
- R10: Data bits 31:4 of the strobe registers are ignored, and bits 31:4 of the status, mask and pending registers read as zero.
- R11: Offset 0x00 holds a 32-bit mode word that reads back as written and drives `mode_cfg`.
- R12: Any other address, including the per-channel banks at 0x200 + 0x20*n, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| period_done | input | 4 | End-of-period pulses, one per channel |
| chan_run | output | 4 | Run enable to each channel |
| mode_cfg | output | 32 | Stored mode word |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume three things about the inputs. `bus_addr`, `bus_wr` and `bus_wdata` are stable and known whenever `bus_req` is high. Each access lasts exactly one cycle. `period_done` is a clean pulse sampled at the clock edge. The bench meets this by changing every input on the falling clock edge and holding each access for a single rising edge. It also raises event pulses on the same falling edge as a pending-register read when it tests the event-during-acknowledge case.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
  localparam int unsigned OFF_MODE   = 'h00;
  localparam int unsigned OFF_RUNSET = 'h04;
  localparam int unsigned OFF_RUNCLR = 'h08;
  localparam int unsigned OFF_RUNSTS = 'h0C;
  localparam int unsigned OFF_MSKSET = 'h10;
  localparam int unsigned OFF_MSKCLR = 'h14;
  localparam int unsigned OFF_MSKSTS = 'h18;
  localparam int unsigned OFF_PEND   = 'h1C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_RUNSET, SEL_RUNCLR, SEL_RUNSTS,
    SEL_MSKSET, SEL_MSKCLR, SEL_MSKSTS, SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/pwm_setclr_bits.sv
module pwm_setclr_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [W-1:0] set_v, clr_v;
  assign set_v = set_stb ? bits : '0;
  assign clr_v = clr_stb ? bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_v) & ~clr_v;
  end
endmodule

// File: rtl/pwm_pend_latch.sv
module pwm_pend_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] events,
  input  logic         ack,
  output logic [W-1:0] q
);
  logic [W-1:0] kept;
  // events win over the acknowledge so nothing is dropped
  assign kept = ack ? '0 : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= kept | events;
  end
endmodule

// File: rtl/pwm_run_irq_ctrl.sv
module pwm_run_irq_ctrl
  import pwm_ctl_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    period_done,
  output logic [NCH-1:0]    chan_run,
  output logic [DATA_W-1:0] mode_cfg,
  output logic              irq
);
  reg_sel_e     sel;
  logic         wr_acc, rd_acc;
  logic [NCH-1:0] mask_q, pend_q;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_MODE):   sel = SEL_MODE;
      ADDR_W'(OFF_RUNSET): sel = SEL_RUNSET;
      ADDR_W'(OFF_RUNCLR): sel = SEL_RUNCLR;
      ADDR_W'(OFF_RUNSTS): sel = SEL_RUNSTS;
      ADDR_W'(OFF_MSKSET): sel = SEL_MSKSET;
      ADDR_W'(OFF_MSKCLR): sel = SEL_MSKCLR;
      ADDR_W'(OFF_MSKSTS): sel = SEL_MSKSTS;
      ADDR_W'(OFF_PEND):   sel = SEL_PEND;
      default:             sel = SEL_NONE;
    endcase
  end

  assign wr_acc = bus_req &  bus_wr;
  assign rd_acc = bus_req & ~bus_wr;

  pwm_setclr_bits #(.W(NCH)) u_run (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_acc && sel == SEL_RUNSET),
    .clr_stb(wr_acc && sel == SEL_RUNCLR),
    .bits(bus_wdata[NCH-1:0]), .q(chan_run)
  );

  pwm_setclr_bits #(.W(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_acc && sel == SEL_MSKSET),
    .clr_stb(wr_acc && sel == SEL_MSKCLR),
    .bits(bus_wdata[NCH-1:0]), .q(mask_q)
  );

  pwm_pend_latch #(.W(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .events(period_done),
    .ack(rd_acc && sel == SEL_PEND),
    .q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      mode_cfg <= '0;
    else if (wr_acc && sel == SEL_MODE) mode_cfg <= bus_wdata;
  end

  always_comb begin
    case (sel)
      SEL_MODE:   bus_rdata = mode_cfg;
      SEL_RUNSTS: bus_rdata = DATA_W'(chan_run);
      SEL_MSKSTS: bus_rdata = DATA_W'(mask_q);
      SEL_PEND:   bus_rdata = DATA_W'(pend_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/pwm_run_irq_chk.sv
module pwm_run_irq_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NCH-1:0]    period_done,
  input logic [NCH-1:0]    chan_run,
  input logic              irq,
  input logic [NCH-1:0]    mask_q,
  input logic [NCH-1:0]    pend_q
);
  logic run_set_w, run_clr_w, sts_w, pend_rd;
  assign run_set_w = bus_req && bus_wr && bus_addr == ADDR_W'('h04);
  assign run_clr_w = bus_req && bus_wr && bus_addr == ADDR_W'('h08);
  assign sts_w     = bus_req && bus_wr && bus_addr == ADDR_W'('h0C);
  assign pend_rd   = bus_req && !bus_wr && bus_addr == ADDR_W'('h1C);

  assert_run_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_set_w |=> ((chan_run & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  assert_run_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr_w |=> ((chan_run & $past(bus_wdata[NCH-1:0])) == '0));

  assert_sts_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sts_w |=> $stable(chan_run));

  assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|period_done) |=> ((pend_q & $past(period_done)) == $past(period_done)));

  assert_ack_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd && period_done == '0) |=> !irq);

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
endmodule

bind pwm_run_irq_ctrl pwm_run_irq_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .period_done(period_done),
  .chan_run(chan_run), .irq(irq), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/pwm_run_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_run_irq_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_req = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  period_done = '0;
  logic [3:0]  chan_run;
  logic [31:0] mode_cfg;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  pwm_run_irq_ctrl u_pwm_run_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .period_done(period_done), .chan_run(chan_run), .mode_cfg(mode_cfg), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic pulse(logic [3:0] ev);
    @(negedge clk);
    period_done = ev;
    @(negedge clk);
    period_done = '0;
  endtask

  task automatic t_reset;
    chk("R1 run", 32'(chan_run), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mode", mode_cfg, 0);
    bus_read('h18, rd); chk("R1 mask", rd, 0);
    bus_read('h1C, rd); chk("R1 pend", rd, 0);
  endtask

  task automatic t_run;
    bus_write('h04, 32'h5); chk("R2 set", 32'(chan_run), 32'h5);
    bus_write('h04, 32'h0); chk("R2 zeros", 32'(chan_run), 32'h5);
    bus_write('h08, 32'h4); chk("R3 clr", 32'(chan_run), 32'h1);
    bus_write('h08, 32'h0); chk("R3 zeros", 32'(chan_run), 32'h1);
    bus_read('h0C, rd);     chk("R4 status", rd, 32'h1);
    bus_write('h0C, 32'hF); chk("R4 ro", 32'(chan_run), 32'h1);
  endtask

  task automatic t_mask;
    bus_write('h10, 32'hA); bus_read('h18, rd); chk("R5 set", rd, 32'hA);
    bus_write('h14, 32'h2); bus_read('h18, rd); chk("R5 clr", rd, 32'h8);
    bus_write('h18, 32'hF); bus_read('h18, rd); chk("R5 ro", rd, 32'h8);
  endtask

  task automatic t_events;
    pulse(4'h1);
    chk("R9 masked out", 32'(irq), 0);
    bus_read('h1C, rd); chk("R7 read", rd, 32'h1);
    bus_read('h1C, rd); chk("R7 cleared", rd, 32'h0);
    pulse(4'h8);
    chk("R9 irq high", 32'(irq), 1);
    bus_read('h1C, rd); chk("R7 read8", rd, 32'h8);
    chk("R9 irq low", 32'(irq), 0);
    pulse(4'h2); pulse(4'h4);
    bus_read('h1C, rd); chk("R6 sticky", rd, 32'h6);
  endtask

  task automatic t_race;
    pulse(4'h2);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = 'h1C; period_done = 4'h8;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_req = 0; period_done = '0;
    chk("R8 read", rd, 32'h2);
    chk("R8 irq", 32'(irq), 1);
    bus_read('h1C, rd); chk("R8 kept", rd, 32'h8);
  endtask

  task automatic t_high;
    bus_write('h04, 32'hFFFF_FFF0); chk("R10 run", 32'(chan_run), 32'h1);
    bus_write('h04, 32'hFFFF_FFFF); bus_read('h0C, rd); chk("R10 status", rd, 32'hF);
    bus_write('h10, 32'hFFFF_FFF0); bus_read('h18, rd); chk("R10 mask", rd, 32'h8);
  endtask

  task automatic t_mode;
    bus_write('h00, 32'hDEAD_BEEF);
    chk("R11 port", mode_cfg, 32'hDEAD_BEEF);
    bus_read('h00, rd); chk("R11 read", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_unmapped;
    bus_write('h08, 32'hF);
    bus_write('h204, 32'hF); chk("R12 write", 32'(chan_run), 0);
    bus_write('h200, 32'h1); chk("R12 mode", mode_cfg, 32'hDEAD_BEEF);
    bus_read('h200, rd); chk("R12 bank", rd, 0);
    bus_read('h020, rd); chk("R12 gap", rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_run;
    t_mask;
    t_events;
    t_race;
    t_high;
    t_mode;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule